// File: doc/BRIEF.md
# Video Parity Error Threshold Monitor

This block watches the parity result of every received video word. It keeps a running error count that the host can see, and it compares that count with a 16-bit limit that the host can program. When the count rises above the limit, an active-low error output goes low. The block also keeps a second count that restarts with every video phase. When a phase ends, it uses that count to decide whether the link may report itself as locked in the handshake that follows the session.

The host loads the limit one byte lane at a time. A new limit is staged and takes effect only at the next video-phase start, so the limit cannot change in the middle of a session. The visible count clears when the host reads the error registers. If automatic clearing is enabled, it also clears at the start of each new video phase. Parity computation is done upstream; this block only sees a one-cycle strobe per failing word.

Top module: `vid_parity_monitor`

## Requirements
- R1: After reset the visible count is 0, `err_n_o` is 1, `lock_ok_o` and `lock_vld_o` are 0, and both the staged and the active limit are 16 (low lane 0x10, high lane 0x00).
- R2: Each cycle with `par_err_i` high adds one to `err_cnt_o`, which is visible after that clock edge. The count saturates at 0xFFFF and never wraps.
- R3: `err_n_o` is 0 exactly when `err_cnt_o` is strictly greater than the active limit. A count equal to the limit keeps it at 1.
- R4: `thr_wr_i[0]` writes `wr_data_i` into limit bits 7:0, and `thr_wr_i[1]` writes it into bits 15:8 of the staged limit.
- R5: The active limit copies the staged limit only in a cycle with `phase_start_i` high. A staged write has no effect on `err_n_o` or on the lock decision until that copy happens.
- R6: A cycle with `rd_clr_i` high reloads the visible count with 1 if `par_err_i` is also high in that cycle, and with 0 otherwise.
- R7: With `auto_clr_i` low, `phase_start_i` leaves the visible count unchanged.
- R8: With `auto_clr_i` high, `phase_start_i` clears the visible count in the same way as R6, so an error caused only by parity goes away when the new phase starts.
- R9: The session count restarts at each `phase_start_i`, in the same way as R6. In the cycle after `phase_end_i`, `lock_vld_o` is high for exactly one cycle. `lock_ok_o` becomes 1 if the session count in the end cycle (strobes of earlier cycles) was not above the active limit, and holds that value until the next phase end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_err_i | input | 1 | One-cycle strobe per video word with a parity error |
| phase_start_i | input | 1 | Video phase begins |
| phase_end_i | input | 1 | Video phase ends |
| rd_clr_i | input | 1 | Host read of the error registers |
| auto_clr_i | input | 1 | Enable clearing at video-phase start |
| thr_wr_i | input | 2 | Byte-lane write enables for the staged limit |
| wr_data_i | input | 8 | Byte written into the selected lanes |
| err_cnt_o | output | 16 | Host-visible error count |
| err_n_o | output | 1 | Active-low error output |
| lock_ok_o | output | 1 | Lock frame is permitted after the last session |
| lock_vld_o | output | 1 | One-cycle pulse marking a new lock decision |

## Verification
The checks assume that an upstream stage delivers at most one parity strobe per cycle. They also assume that phase start and phase end never share a cycle, and that the host does not write a limit lane in the same cycle as a phase start. The bench drives only one control event per cycle, and it always stages a limit in cycles before the phase start that loads it. Under these conditions, each counter can change only by one step or by a clear, and the active limit can change only at a phase start.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam logic [CNT_W-1:0] THR_RST = 16'h0010;
endpackage

// File: rtl/vpm_sat_cnt.sv
module vpm_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         en;

  always_comb begin
    en    = clr_i | inc_i;
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = {{(W-1){1'b0}}, inc_i};
    else if (inc_i && (cnt_q != MAXV))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (en)
      cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/vpm_thr_bank.sv
module vpm_thr_bank #(
  parameter int unsigned W      = 16,
  parameter int unsigned BW     = 8,
  parameter logic [W-1:0] RSTV  = 16'h0010,
  localparam int unsigned NLANE = W / BW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLANE-1:0] lane_wr_i,
  input  logic [BW-1:0]    data_i,
  input  logic             load_i,
  output logic [W-1:0]     act_o
);
  logic [W-1:0] stage_q;
  logic [W-1:0] act_q;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [BW-1:0] lane_d;
    always_comb lane_d = lane_wr_i[g] ? data_i : stage_q[g*BW +: BW];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stage_q[g*BW +: BW] <= RSTV[g*BW +: BW];
      else if (lane_wr_i[g])
        stage_q[g*BW +: BW] <= lane_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      act_q <= RSTV;
    else if (load_i)
      act_q <= stage_q;
  end

  assign act_o = act_q;
endmodule

// File: rtl/vid_parity_monitor.sv
module vid_parity_monitor
  import vpm_pkg::*;
#(
  parameter int unsigned CW  = CNT_W,
  parameter int unsigned BW  = BYTE_W,
  parameter logic [CW-1:0] RSTV = THR_RST,
  localparam int unsigned NLANE = CW / BW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             par_err_i,
  input  logic             phase_start_i,
  input  logic             phase_end_i,
  input  logic             rd_clr_i,
  input  logic             auto_clr_i,
  input  logic [NLANE-1:0] thr_wr_i,
  input  logic [BW-1:0]    wr_data_i,
  output logic [CW-1:0]    err_cnt_o,
  output logic             err_n_o,
  output logic             lock_ok_o,
  output logic             lock_vld_o
);
  logic [CW-1:0] act_thr;
  logic [CW-1:0] host_cnt;
  logic [CW-1:0] sess_cnt;
  logic          host_clr;
  logic          lock_ok_q, lock_ok_d;
  logic          lock_vld_q, lock_vld_d;

  assign host_clr = rd_clr_i | (auto_clr_i & phase_start_i);

  vpm_thr_bank #(.W(CW), .BW(BW), .RSTV(RSTV)) u_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_wr_i(thr_wr_i),
    .data_i   (wr_data_i),
    .load_i   (phase_start_i),
    .act_o    (act_thr)
  );

  vpm_sat_cnt #(.W(CW)) u_host_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr_i(host_clr),
    .inc_i(par_err_i),
    .cnt_o(host_cnt)
  );

  vpm_sat_cnt #(.W(CW)) u_sess_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr_i(phase_start_i),
    .inc_i(par_err_i),
    .cnt_o(sess_cnt)
  );

  always_comb begin
    lock_vld_d = phase_end_i;
    lock_ok_d  = phase_end_i ? (sess_cnt <= act_thr) : lock_ok_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_ok_q  <= 1'b0;
      lock_vld_q <= 1'b0;
    end else begin
      lock_ok_q  <= lock_ok_d;
      lock_vld_q <= lock_vld_d;
    end
  end

  assign err_cnt_o  = host_cnt;
  assign err_n_o    = ~(host_cnt > act_thr);
  assign lock_ok_o  = lock_ok_q;
  assign lock_vld_o = lock_vld_q;
endmodule

// File: rtl/vpm_chk.sv
module vpm_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          par_err_i,
  input logic          phase_start_i,
  input logic          phase_end_i,
  input logic          rd_clr_i,
  input logic          auto_clr_i,
  input logic [CW-1:0] err_cnt_o,
  input logic          err_n_o,
  input logic          lock_vld_o,
  input logic [CW-1:0] act_thr
);
  logic any_clr;
  assign any_clr = rd_clr_i | (auto_clr_i & phase_start_i);

  assert_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt_o == {CW{1'b1}} && !any_clr) |=> (err_cnt_o == {CW{1'b1}}));

  assert_no_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_clr |=> (err_cnt_o >= $past(err_cnt_o)));

  assert_err_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !err_n_o |-> (err_cnt_o != '0));

  assert_thr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_start_i |=> $stable(act_thr));

  assert_rd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> (err_cnt_o <= 1));

  assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_start_i && !auto_clr_i && !rd_clr_i && !par_err_i) |=> $stable(err_cnt_o));

  assert_auto_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_start_i && auto_clr_i) |=> (err_cnt_o <= 1));

  assert_vld_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end_i |=> lock_vld_o);

  assert_vld_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_end_i |=> !lock_vld_o);
endmodule

bind vid_parity_monitor vpm_chk #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .par_err_i    (par_err_i),
  .phase_start_i(phase_start_i),
  .phase_end_i  (phase_end_i),
  .rd_clr_i     (rd_clr_i),
  .auto_clr_i   (auto_clr_i),
  .err_cnt_o    (err_cnt_o),
  .err_n_o      (err_n_o),
  .lock_vld_o   (lock_vld_o),
  .act_thr      (act_thr)
);

// File: tb/vid_parity_monitor_tb.sv
module vid_parity_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        par_err_i = 1'b0;
  logic        phase_start_i = 1'b0;
  logic        phase_end_i = 1'b0;
  logic        rd_clr_i = 1'b0;
  logic        auto_clr_i = 1'b0;
  logic [1:0]  thr_wr_i = 2'b00;
  logic [7:0]  wr_data_i = 8'h00;
  logic [15:0] err_cnt_o;
  logic        err_n_o;
  logic        lock_ok_o;
  logic        lock_vld_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vid_parity_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .par_err_i(par_err_i),
    .phase_start_i(phase_start_i), .phase_end_i(phase_end_i),
    .rd_clr_i(rd_clr_i), .auto_clr_i(auto_clr_i),
    .thr_wr_i(thr_wr_i), .wr_data_i(wr_data_i),
    .err_cnt_o(err_cnt_o), .err_n_o(err_n_o),
    .lock_ok_o(lock_ok_o), .lock_vld_o(lock_vld_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_thr(logic [15:0] t);
    thr_wr_i = 2'b01; wr_data_i = t[7:0];  tick();
    thr_wr_i = 2'b10; wr_data_i = t[15:8]; tick();
    thr_wr_i = 2'b00; wr_data_i = 8'h00;
  endtask

  task automatic pulse_start();
    phase_start_i = 1'b1; tick(); phase_start_i = 1'b0;
  endtask

  task automatic strobe();
    par_err_i = 1'b1; tick(); par_err_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] thr_list [9];
    thr_list = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd7, 16'd16, 16'd255, 16'd256, 16'd300};

    #5;
    // R1: reset values
    chk("R1 cnt", err_cnt_o, 0);
    chk("R1 err_n", err_n_o, 1);
    chk("R1 lock_ok", lock_ok_o, 0);
    chk("R1 lock_vld", lock_vld_o, 0);
    rst_n = 1'b1;
    tick();

    // R1: default limit 16 -> 16 errors keep err_n high, 17th drops it
    for (int k = 1; k <= 17; k++) begin
      strobe();
      chk("R1 default limit err_n", err_n_o, (k > 16) ? 0 : 1);
    end
    // R6: plain read clears to 0
    rd_clr_i = 1'b1; tick(); rd_clr_i = 1'b0;
    chk("R6 read clear cnt", err_cnt_o, 0);
    chk("R6 read clear err_n", err_n_o, 1);
    // R6: read coinciding with strobe gives 1
    strobe(); strobe();
    rd_clr_i = 1'b1; par_err_i = 1'b1; tick(); rd_clr_i = 1'b0; par_err_i = 1'b0;
    chk("R6 read with strobe", err_cnt_o, 1);

    // R5: staged write does not act before phase start
    set_thr(16'd2);
    repeat (4) strobe();
    chk("R5 cnt before load", err_cnt_o, 5);
    chk("R5 old limit still active", err_n_o, 1);
    // R7: auto off -> phase start keeps count
    auto_clr_i = 1'b0;
    pulse_start();
    chk("R7 count kept", err_cnt_o, 5);
    chk("R5 new limit active", err_n_o, 0);

    // R3 R4 R8 R9: sweep of limits and error counts, auto clearing on
    auto_clr_i = 1'b1;
    foreach (thr_list[i]) begin
      for (int n = 0; n <= thr_list[i] + 2; n++) begin
        if (thr_list[i] > 16 && n > 3 && n < thr_list[i] - 1) continue;
        set_thr(thr_list[i]);
        pulse_start();
        chk("R8 auto clear", err_cnt_o, 0);
        for (int k = 1; k <= n; k++) strobe();
        chk("R2 count", err_cnt_o, n);
        chk("R3 R4 err_n vs limit", err_n_o, (n > thr_list[i]) ? 0 : 1);
        phase_end_i = 1'b1; tick(); phase_end_i = 1'b0;
        chk("R9 vld pulse", lock_vld_o, 1);
        chk("R9 lock decision", lock_ok_o, (n <= thr_list[i]) ? 1 : 0);
        tick();
        chk("R9 vld one cycle", lock_vld_o, 0);
        chk("R9 lock held", lock_ok_o, (n <= thr_list[i]) ? 1 : 0);
      end
    end

    // R8: auto clear with coinciding strobe gives 1
    strobe(); strobe();
    phase_start_i = 1'b1; par_err_i = 1'b1; tick();
    phase_start_i = 1'b0; par_err_i = 1'b0;
    chk("R8 clear with strobe", err_cnt_o, 1);

    // R2: saturation with limit 0xFFFF
    set_thr(16'hFFFF);
    pulse_start();
    par_err_i = 1'b1;
    repeat (65540) tick();
    par_err_i = 1'b0;
    chk("R2 saturate", err_cnt_o, 16'hFFFF);
    chk("R3 equal limit keeps err_n", err_n_o, 1);
    phase_end_i = 1'b1; tick(); phase_end_i = 1'b0;
    chk("R9 lock at saturated equal", lock_ok_o, 1);
    auto_clr_i = 1'b0;
    set_thr(16'hFFFE);
    pulse_start();
    chk("R7 saturated kept", err_cnt_o, 16'hFFFF);
    chk("R3 above limit", err_n_o, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule